// File: doc/BRIEF.md
# Flash Burst and Page Read Sequencer

This block sits behind the read port of a parallel NOR flash model. It produces the word address and a ready strobe for each word read from an internal lookup array, and it returns that word on a registered data output. Every latency is counted in clock cycles.

Out of reset it serves single-word asynchronous-style reads. Each read takes a long initial latency unless it falls in the same 4- or 8-word page as the previous completed read, in which case a shorter page latency applies. Once a one-cycle burst-enable command has been seen, every later access becomes a clocked burst. A burst waits out the initial latency and then delivers one word per clock. It either wraps inside an aligned block of 4, 8, 16 or 32 words, in linear or interleaved order, or walks the whole address space until it is stopped. Dropping the chip enable stops any activity at once. A new address strobe abandons the access in progress and starts over.

The array holds a computed pattern, so the expected data for any address is known. Word `a` holds `((a * DATA_MULT) mod 2^DATA_W) XOR DATA_SEED`.

Top module: `flash_read_seq`

## Requirements
- R1: After reset `rdy` is low and the port is in single-word mode: an access made before any burst-enable command returns exactly one word.
- R2: An access is captured on a rising edge at which `ce` is high and `avalid_n` is low. `rdy` is low in the cycle after that edge. When a word is delivered, `waddr` is its address and `rdata` is `((waddr*DATA_MULT) mod 2^DATA_W) XOR DATA_SEED` in the same cycle.
- R3: A single-word access that is not a page hit shows its word, with `rdy` high, for one cycle after the INIT_LAT-th edge counted from the capture edge.
- R4: A single-word access is a page hit when the previous completed single-word access lies in the same page. `page8`=0 selects a 4-word page (address bits above bit 1 compared) and `page8`=1 selects an 8-word page (bits above bit 2 compared). A hit delivers after PAGE_LAT edges instead of INIT_LAT.
- R5: A one-cycle pulse on `burst_cmd` turns burst mode on until reset. An access captured on the same edge as the pulse is still a single-word access, and accesses captured on later edges are bursts that deliver their first word after INIT_LAT edges.
- R6: `bmode` 0 (and the unused code 3) selects linear order. Word k is `base + ((off + k) mod L)`, where L = 4 << `blen` (`blen` 0..3 gives 4, 8, 16, 32), base is the start address rounded down to a multiple of L, and off is the remainder. Exactly L words arrive on consecutive cycles, then `rdy` falls.
- R7: `bmode` 1 selects interleaved order, with word k = `base + (off XOR k)`, again L words on consecutive cycles.
- R8: `bmode` 2 selects continuous order, with word k = `(start + k) mod 2^ADDR_W`, so it rolls from the top address to zero. It runs with no end until `ce` falls or a new strobe arrives.
- R9: With `ce` low at an edge, that edge captures nothing, `rdy` is low after it, any burst ends, and the page history is cleared, so the next single-word access takes INIT_LAT.
- R10: A strobe captured while a burst is delivering stops that burst. `rdy` is low in the next cycle and the new access follows its own latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Chip enable, active high |
| avalid_n | input | 1 | Address-valid strobe, active low |
| start_addr | input | ADDR_W | Start address of the access |
| bmode | input | 2 | Burst order: 0 linear, 1 interleaved, 2 continuous, 3 linear |
| blen | input | 2 | Burst block size code: 4 << blen words |
| page8 | input | 1 | Page size for single-word reads: 0 four words, 1 eight words |
| burst_cmd | input | 1 | One-cycle pulse that turns on burst mode |
| waddr | output | ADDR_W | Array word address of the delivered word |
| rdy | output | 1 | High only in cycles carrying a valid word |
| rdata | output | DATA_W | Word read from the internal array |

## Verification
Two pairs of events can land on one clock edge. In the first, the burst-enable command and an address strobe arrive together. The bench pulses both on the same edge and requires a single word after INIT_LAT, with the next access streaming a full block. In the second, a strobe arrives while a 32-word linear burst is three words in. The bench then requires `rdy` to drop for the cycle after the strobe and the new interleaved sequence to follow at full latency, with no stray word from the old burst. The order sweeps cover every block size, both wrapping orders and start offsets at, next to and across the block boundary. Every expected address and data word is derived arithmetically.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    BM_LINEAR    = 2'd0,
    BM_INTERLEAVE = 2'd1,
    BM_CONTIN    = 2'd2,
    BM_LINEAR_ALT = 2'd3
  } bmode_e;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_WAIT   = 2'd1,
    PH_STREAM = 2'd2
  } phase_e;

endpackage

// File: rtl/flash_seq_addr_gen.sv
module flash_seq_addr_gen
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] start,
  input  logic [ADDR_W-1:0] beat,
  input  bmode_e            mode,
  input  logic [1:0]        len,
  output logic [ADDR_W-1:0] addr
);

  logic [ADDR_W-1:0] blk_mask;

  assign blk_mask = ADDR_W'((4 << len) - 1);

  always_comb begin
    case (mode)
      BM_INTERLEAVE: addr = (start & ~blk_mask) | ((start ^ beat) & blk_mask);
      BM_CONTIN:     addr = start + beat;
      default:       addr = (start & ~blk_mask) | ((start + beat) & blk_mask);
    endcase
  end

endmodule

// File: rtl/flash_seq_page_cmp.sv
module flash_seq_page_cmp #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] tag,
  input  logic              tag_vld,
  input  logic              page8,
  output logic              hit
);

  logic [ADDR_W-1:0] hi_mask;

  assign hi_mask = page8 ? ~ADDR_W'(7) : ~ADDR_W'(3);
  assign hit     = tag_vld && (((addr ^ tag) & hi_mask) == '0);

endmodule

// File: rtl/flash_seq_array.sv
module flash_seq_array #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              DATA_MULT = 40503,
  parameter logic [DATA_W-1:0] DATA_SEED = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DATA_W'(i * DATA_MULT) ^ DATA_SEED;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_data <= mem[rd_addr];
    end
  end

endmodule

// File: rtl/flash_read_seq.sv
module flash_read_seq
  import flash_seq_pkg::*;
#(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_W    = 16,
  parameter int              INIT_LAT  = 4,
  parameter int              PAGE_LAT  = 2,
  parameter int              DATA_MULT = 40503,
  parameter logic [DATA_W-1:0] DATA_SEED = 16'h5A5A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce,
  input  logic              avalid_n,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        bmode,
  input  logic [1:0]        blen,
  input  logic              page8,
  input  logic              burst_cmd,
  output logic [ADDR_W-1:0] waddr,
  output logic              rdy,
  output logic [DATA_W-1:0] rdata
);

  localparam int CNT_W = $clog2(INIT_LAT + 1);
  localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_LAT - 1);
  localparam logic [CNT_W-1:0] PAGE_LOAD = CNT_W'(PAGE_LAT - 1);

  phase_e            phase;
  bmode_e            mode_q;
  logic [1:0]        len_q;
  logic [ADDR_W-1:0] cap_addr;
  logic [ADDR_W-1:0] beat;
  logic [ADDR_W-1:0] page_tag;
  logic [CNT_W-1:0]  cnt;
  logic              sync_q;
  logic              burst_on;
  logic              page_vld;

  logic [ADDR_W-1:0] beat_addr;
  logic              page_hit;
  logic              capture;
  logic              present;
  logic              last_beat;
  logic              cont_q;

  flash_seq_addr_gen #(.ADDR_W(ADDR_W)) u_agen (
    .start (cap_addr),
    .beat  (beat),
    .mode  (mode_q),
    .len   (len_q),
    .addr  (beat_addr)
  );

  flash_seq_page_cmp #(.ADDR_W(ADDR_W)) u_page (
    .addr    (start_addr),
    .tag     (page_tag),
    .tag_vld (page_vld),
    .page8   (page8),
    .hit     (page_hit)
  );

  flash_seq_array #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .DATA_MULT (DATA_MULT),
    .DATA_SEED (DATA_SEED)
  ) u_arr (
    .clk     (clk),
    .rd_en   (present),
    .rd_addr (beat_addr),
    .rd_data (rdata)
  );

  assign capture   = ce && !avalid_n;
  assign present   = ce && avalid_n &&
                     ((phase == PH_WAIT && cnt == '0) || phase == PH_STREAM);
  assign last_beat = (mode_q != BM_CONTIN) && (beat == ADDR_W'((4 << len_q) - 1));
  assign cont_q    = sync_q && (mode_q == BM_CONTIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      mode_q   <= BM_LINEAR;
      len_q    <= '0;
      cap_addr <= '0;
      beat     <= '0;
      page_tag <= '0;
      cnt      <= '0;
      sync_q   <= 1'b0;
      burst_on <= 1'b0;
      page_vld <= 1'b0;
      waddr    <= '0;
      rdy      <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (burst_cmd) begin
        burst_on <= 1'b1;
      end
      if (!ce) begin
        phase    <= PH_IDLE;
        page_vld <= 1'b0;
      end else if (capture) begin
        cap_addr <= start_addr;
        mode_q   <= bmode_e'(bmode);
        len_q    <= blen;
        sync_q   <= burst_on;
        beat     <= '0;
        phase    <= PH_WAIT;
        if (burst_on) begin
          cnt      <= INIT_LOAD;
          page_vld <= 1'b0;
        end else begin
          cnt <= page_hit ? PAGE_LOAD : INIT_LOAD;
        end
      end else if (phase == PH_WAIT && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (present) begin
        rdy   <= 1'b1;
        waddr <= beat_addr;
        beat  <= beat + 1'b1;
        if (!sync_q) begin
          phase    <= PH_IDLE;
          page_vld <= 1'b1;
          page_tag <= cap_addr;
        end else if (last_beat) begin
          phase <= PH_IDLE;
        end else begin
          phase <= PH_STREAM;
        end
      end
    end
  end

endmodule

// File: rtl/flash_read_seq_chk.sv
module flash_read_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce,
  input logic              avalid_n,
  input logic              burst_cmd,
  input logic              rdy,
  input logic [ADDR_W-1:0] waddr,
  input logic              burst_on,
  input logic              sync_q,
  input logic              cont_q,
  input logic [1:0]        len_q
);

  logic [ADDR_W-1:0] blk_mask;
  assign blk_mask = ADDR_W'((4 << len_q) - 1);

  // R9: a word is only delivered after an edge that saw the chip enabled
  p_rdy_needs_ce_r9: assert property (@(posedge clk) disable iff (rst)
    rdy |-> $past(ce));

  // R2: the cycle after a capture never carries a word
  p_quiet_after_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (ce && !avalid_n) |=> !rdy);

  // R3: a single-word access never delivers two consecutive words
  p_single_word_r3: assert property (@(posedge clk) disable iff (rst)
    (rdy && !sync_q) |=> !rdy);

  // R5: burst mode only turns on through the command
  p_cmd_only_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_on) |-> $past(burst_cmd));

  // R6: consecutive words of a wrapping burst stay in one aligned block
  p_same_block_r6: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(rdy) && sync_q && !cont_q) |->
      (((waddr ^ $past(waddr)) & ~blk_mask) == '0));

  // R8: continuous order steps by one, rolling over at the top
  p_cont_step_r8: assert property (@(posedge clk) disable iff (rst)
    (rdy && $past(rdy) && cont_q) |-> (waddr == ADDR_W'($past(waddr) + 1'b1)));

endmodule

bind flash_read_seq flash_read_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce        (ce),
  .avalid_n  (avalid_n),
  .burst_cmd (burst_cmd),
  .rdy       (rdy),
  .waddr     (waddr),
  .burst_on  (burst_on),
  .sync_q    (sync_q),
  .cont_q    (cont_q),
  .len_q     (len_q)
);

// File: tb/flash_read_seq_test.sv
`timescale 1ns/1ps
module flash_read_seq_test;

  localparam int AW    = 8;
  localparam int DW    = 16;
  localparam int ILAT  = 4;
  localparam int PLAT  = 2;
  localparam int SPAN  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce = 1'b1;
  logic          avalid_n = 1'b1;
  logic [AW-1:0] start_addr = '0;
  logic [1:0]    bmode = '0;
  logic [1:0]    blen = '0;
  logic          page8 = 1'b0;
  logic          burst_cmd = 1'b0;
  logic [AW-1:0] waddr;
  logic          rdy;
  logic [DW-1:0] rdata;

  int total = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_read_seq #(
    .ADDR_W(AW), .DATA_W(DW), .INIT_LAT(ILAT), .PAGE_LAT(PLAT),
    .DATA_MULT(40503), .DATA_SEED(16'h5A5A)
  ) uut (
    .clk(clk), .rst(rst), .ce(ce), .avalid_n(avalid_n),
    .start_addr(start_addr), .bmode(bmode), .blen(blen), .page8(page8),
    .burst_cmd(burst_cmd), .waddr(waddr), .rdy(rdy), .rdata(rdata)
  );

  function automatic int exp_data(input int a);
    return ((a * 40503) & 16'hFFFF) ^ 16'h5A5A;
  endfunction

  function automatic int exp_addr(input int st, input int md, input int lc, input int k);
    int len, off, base;
    len  = 4 << lc;
    off  = st % len;
    base = st - off;
    if (md == 2) return (st + k) % SPAN;
    if (md == 1) return base + (off ^ k);
    return base + ((off + k) % len);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Starts at a negedge; leaves at the negedge after the last word.
  task automatic access(input int st, input int md, input int lc, input bit p8,
                        input int lat, input int nwords, input string req);
    int ea;
    avalid_n   = 1'b0;
    start_addr = AW'(st);
    bmode      = 2'(md);
    blen       = 2'(lc);
    page8      = p8;
    @(posedge clk);
    @(negedge clk);
    avalid_n  = 1'b1;
    burst_cmd = 1'b0;
    chk(rdy == 1'b0, req, int'(rdy), 0);
    for (int n = 1; n < lat; n++) begin
      @(negedge clk);
      chk(rdy == 1'b0, req, int'(rdy), 0);
    end
    for (int k = 0; k < nwords; k++) begin
      @(negedge clk);
      ea = exp_addr(st, md, lc, k);
      chk(rdy == 1'b1 && int'(waddr) == ea, req, int'(waddr), ea);
      chk(int'(rdata) == exp_data(ea), req, int'(rdata), exp_data(ea));
    end
  endtask

  task automatic tail(input string req);
    @(negedge clk);
    chk(rdy == 1'b0, req, int'(rdy), 0);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy == 1'b0, "R1", int'(rdy), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R3: single word, full latency, no page history
    access(8'h10, 0, 3, 1'b0, ILAT, 1, "R3");
    tail("R1");
    // R4: page hits and misses for both page sizes
    access(8'h13, 0, 0, 1'b0, PLAT, 1, "R4");
    tail("R4");
    access(8'h14, 0, 0, 1'b0, ILAT, 1, "R4");
    tail("R4");
    access(8'h17, 0, 0, 1'b1, PLAT, 1, "R4");
    tail("R4");
    access(8'h18, 0, 0, 1'b1, ILAT, 1, "R4");
    tail("R4");
    // R9: chip enable low clears the page history
    ce = 1'b0;
    @(negedge clk);
    ce = 1'b1;
    access(8'h19, 0, 0, 1'b1, ILAT, 1, "R9");
    tail("R9");
    // R9: a strobe with chip enable low is not captured
    ce = 1'b0;
    avalid_n = 1'b0;
    start_addr = 8'h33;
    @(negedge clk);
    avalid_n = 1'b1;
    ce = 1'b1;
    for (int n = 0; n < ILAT + 2; n++) begin
      @(negedge clk);
      chk(rdy == 1'b0, "R9", int'(rdy), 0);
    end

    // R5: command and strobe on the same edge -> still one word
    burst_cmd = 1'b1;
    access(8'h20, 0, 0, 1'b0, ILAT, 1, "R5");
    tail("R5");
    access(8'h21, 0, 0, 1'b0, ILAT, 4, "R5");
    tail("R5");

    // R6 / R7: sweep block sizes and start offsets
    for (int md = 0; md < 2; md++) begin
      for (int lc = 0; lc < 4; lc++) begin
        for (int j = 0; j < 4; j++) begin
          int len, off, st;
          len = 4 << lc;
          off = (j == 0) ? 0 : (j == 1) ? 1 : (j == 2) ? len - 1 : len / 2 + 1;
          st  = (md == 0 ? 8'h40 : 8'hC0) + off;
          access(st, md, lc, 1'b0, ILAT, len, md == 0 ? "R6" : "R7");
          tail(md == 0 ? "R6" : "R7");
        end
      end
    end
    // R6: code 3 behaves as linear
    access(8'h4B, 3, 1, 1'b0, ILAT, 8, "R6");
    tail("R6");

    // R8: continuous order rolls over, ends when chip enable falls
    access(8'hFD, 2, 0, 1'b0, ILAT, 6, "R8");
    ce = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b0, "R9", int'(rdy), 0);
    @(negedge clk);
    chk(rdy == 1'b0, "R9", int'(rdy), 0);
    ce = 1'b1;

    // R10: a new strobe during a long burst restarts the sequence
    access(8'h80, 0, 3, 1'b0, ILAT, 3, "R10");
    access(8'h05, 1, 0, 1'b0, ILAT, 4, "R10");
    tail("R10");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule